// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Tracker

This block holds the per-CPU view of which interrupt is currently being serviced, and how the interrupts it preempted are ordered. An arbiter outside the block presents the best pending ID. When the CPU performs an acknowledge, the block decides whether that ID may preempt the running one. If it may, the block returns the ID, asks for its pending state to be cleared, and makes it the running interrupt. The running priority then becomes the priority of that ID.

Each source owns one entry in a back-link table. That entry records which interrupt was running when the source was taken, so the preempted interrupts form a singly linked chain headed by the running ID. An end-of-interrupt write for the running ID pops one link. A write for an ID deeper in the chain starts a small walker. The walker follows one link per clock and splices the completed ID out of the chain, and a busy flag holds off further operations until it is done. On completion of a level-sensitive source whose line is still high, the block requests that the source be made pending again.

Top module: `irq_nest_tracker`

## Requirements
- R1: An acknowledge returns ID 1023 and changes no state when any of the following holds: the presented ID is 1023; it is at or beyond NUM_SRC; its 8-bit priority is not strictly below the running priority; an end-of-interrupt is presented in the same cycle.
- R2: An accepted acknowledge returns the presented ID on `ack_id` in the same cycle and pulses `pend_clr` with that ID. At the next edge the presented ID becomes `run_id` and its priority becomes `run_prio`, and the previous `run_id` is stored in its back-link entry.
- R3: After reset `run_id` is 1023, `run_prio` is 0x100 and `busy` is 0. Whenever `run_id` is 1023, `run_prio` is 0x100.
- R4: An end-of-interrupt takes its ID from bits [9:0] of `eoi_data`. All higher bits are ignored.
- R5: An end-of-interrupt is ignored when its ID is at or beyond NUM_SRC (1023 included) or when `run_id` is 1023. An ignored write raises no `pend_set`.
- R6: Completing the running ID makes its back-link entry the new `run_id`. The running priority becomes that entry's configured priority, or 0x100 if the entry is 1023.
- R7: Completing a valid ID that is not running walks the chain from `run_id`. The link that points at the completed ID is replaced by the completed ID's own link. If the walk reaches 1023 first, nothing changes. `run_id` and `run_prio` are not changed by the walk.
- R8: An accepted end-of-interrupt pulses `pend_set` with the completed ID in the same cycle exactly when that source's `src_level`, `src_enable`, `src_line` and `src_to_me` bits are all 1.
- R9: The walk examines one link per clock, and `busy` stays high for exactly that many cycles. Acknowledges (returning 1023) and end-of-interrupts presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_cfg | input | NUM_SRC*8 | Configured priority of each source, source i in bits [8i+7:8i] |
| ack_req | input | 1 | Acknowledge read this cycle |
| top_id | input | 10 | Highest pending ID from the arbiter (1023 when none) |
| ack_id | output | 10 | Acknowledge result, 1023 when refused |
| pend_clr | output | 1 | Clear pending of `pend_clr_id` |
| pend_clr_id | output | 10 | ID whose pending state is cleared |
| eoi_req | input | 1 | End-of-interrupt write this cycle |
| eoi_data | input | 32 | Written value; bits [9:0] are the ID |
| src_level | input | NUM_SRC | 1 = source is level sensitive |
| src_enable | input | NUM_SRC | Source enable |
| src_line | input | NUM_SRC | Current input line state |
| src_to_me | input | NUM_SRC | Source targets this CPU |
| pend_set | output | 1 | Set pending of `pend_set_id` again |
| pend_set_id | output | 10 | ID to re-pend |
| busy | output | 1 | Chain walk in progress |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | 9 | Running priority, 0x100 when idle |

## Verification
The bench nests three interrupts and completes the middle one out of order. A design that pops like a stack would show the wrong running ID on the following completions. A design that spliced the wrong link would return to a completed interrupt. A priority tie and a higher-priority candidate are both offered during nesting: a comparison of less-or-equal would wrongly accept the tie. Completions with junk upper data bits, out-of-range IDs, IDs that are absent from the chain, and completions while idle are all checked for silence. Every combination of the four re-pend qualifiers is swept. A long pseudo-random mix of operations is compared against a behavioural chain model, including the exact number of busy cycles and the refusal of an acknowledge during a walk.

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker #(
  parameter int NUM_SRC = 16,
  parameter int ID_W    = 10,
  parameter int PR_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC*PR_W-1:0] prio_cfg,
  input  logic                    ack_req,
  input  logic [ID_W-1:0]         top_id,
  output logic [ID_W-1:0]         ack_id,
  output logic                    pend_clr,
  output logic [ID_W-1:0]         pend_clr_id,
  input  logic                    eoi_req,
  input  logic [31:0]             eoi_data,
  input  logic [NUM_SRC-1:0]      src_level,
  input  logic [NUM_SRC-1:0]      src_enable,
  input  logic [NUM_SRC-1:0]      src_line,
  input  logic [NUM_SRC-1:0]      src_to_me,
  output logic                    pend_set,
  output logic [ID_W-1:0]         pend_set_id,
  output logic                    busy,
  output logic [ID_W-1:0]         run_id,
  output logic [PR_W:0]           run_prio
);
  localparam int IX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ID_W-1:0] SPUR = '1;
  localparam logic [PR_W:0] IDLE_PRIO = {1'b1, {PR_W{1'b0}}};
  localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_SRC);

  logic [PR_W-1:0] prio_arr [NUM_SRC];
  logic [ID_W-1:0] link_q [NUM_SRC];
  logic [IX_W-1:0] walk_cur;
  logic [ID_W-1:0] walk_tgt;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
    assign prio_arr[g] = prio_cfg[g*PR_W +: PR_W];
  end

  logic            top_ok, ack_go, eoi_ok, unused_hi;
  logic [PR_W:0]   top_prio, back_prio;
  logic [ID_W-1:0] eoi_id, back, walk_nxt;
  logic [IX_W-1:0] eix;

  assign unused_hi = ^eoi_data[31:ID_W];
  assign top_ok    = top_id != SPUR && top_id < LIMIT;
  assign top_prio  = {1'b0, prio_arr[top_id[IX_W-1:0]]};
  assign ack_go    = ack_req && !eoi_req && !busy && top_ok && top_prio < run_prio;
  assign ack_id    = ack_go ? top_id : SPUR;
  assign pend_clr  = ack_go;
  assign pend_clr_id = top_id;

  assign eoi_id    = eoi_data[ID_W-1:0];
  assign eix       = eoi_id[IX_W-1:0];
  assign eoi_ok    = eoi_req && !busy && eoi_id < LIMIT && run_id != SPUR;
  assign pend_set  = eoi_ok && src_level[eix] && src_enable[eix] && src_line[eix] && src_to_me[eix];
  assign pend_set_id = eoi_id;

  assign back      = link_q[eix];
  assign back_prio = (back == SPUR) ? IDLE_PRIO : {1'b0, prio_arr[back[IX_W-1:0]]};
  assign walk_nxt  = link_q[walk_cur];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_id   <= SPUR;
      run_prio <= IDLE_PRIO;
      busy     <= 1'b0;
      walk_cur <= '0;
      walk_tgt <= SPUR;
      for (int i = 0; i < NUM_SRC; i++) link_q[i] <= SPUR;
    end else if (ack_go) begin
      link_q[top_id[IX_W-1:0]] <= run_id;
      run_id   <= top_id;
      run_prio <= top_prio;
    end else if (eoi_ok) begin
      if (eoi_id == run_id) begin
        run_id   <= back;
        run_prio <= back_prio;
      end else begin
        busy     <= 1'b1;
        walk_cur <= run_id[IX_W-1:0];
        walk_tgt <= eoi_id;
      end
    end else if (busy) begin
      if (walk_nxt == SPUR) begin
        busy <= 1'b0;
      end else if (walk_nxt == walk_tgt) begin
        link_q[walk_cur] <= link_q[walk_tgt[IX_W-1:0]];
        busy <= 1'b0;
      end else begin
        walk_cur <= walk_nxt[IX_W-1:0];
      end
    end
  end

  a_r3_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
    run_id == SPUR |-> run_prio == IDLE_PRIO);
  a_r2_ack_load: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> run_id == $past(pend_clr_id));
  a_r1_prio_drop: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> run_prio < $past(run_prio));
  a_r9_hold_walk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(run_id) && $stable(run_prio));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    run_id == SPUR |-> !pend_set);
  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_id == SPUR || run_id < LIMIT);
endmodule

// File: tb/irq_nest_tracker_test.sv
`timescale 1ns/1ps
module irq_nest_tracker_test;
  localparam int N = 16;
  logic clk = 0, rst_n = 0;
  logic [N*8-1:0] prio_cfg = '0;
  logic ack_req = 0, eoi_req = 0;
  logic [9:0] top_id = 10'h3FF;
  logic [31:0] eoi_data = 0;
  logic [N-1:0] lvl = 0, en = 0, ln = 0, tg = 0;
  logic [9:0] ack_id, pend_clr_id, pend_set_id, run_id;
  logic pend_clr, pend_set, busy;
  logic [8:0] run_prio;

  irq_nest_tracker uut (
    .clk(clk), .rst_n(rst_n), .prio_cfg(prio_cfg),
    .ack_req(ack_req), .top_id(top_id), .ack_id(ack_id),
    .pend_clr(pend_clr), .pend_clr_id(pend_clr_id),
    .eoi_req(eoi_req), .eoi_data(eoi_data),
    .src_level(lvl), .src_enable(en), .src_line(ln), .src_to_me(tg),
    .pend_set(pend_set), .pend_set_id(pend_set_id),
    .busy(busy), .run_id(run_id), .run_prio(run_prio));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int pr [N];
  int m_link [N];
  int m_run = 1023, m_rp = 256;
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(string r, int a, int e);
    n_chk++;
    if (a != e) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  function automatic int mprio(int id);
    return (id == 1023) ? 256 : pr[id];
  endfunction

  task automatic push_cfg();
    for (int i = 0; i < N; i++) prio_cfg[i*8 +: 8] = pr[i][7:0];
  endtask

  task automatic check_run(string r);
    chk({r, " run_id"}, int'(run_id), m_run);
    chk({r, " run_prio"}, int'(run_prio), m_rp);
  endtask

  task automatic do_ack(int t);
    bit ok;
    @(negedge clk);
    top_id = t[9:0]; ack_req = 1; #1;
    ok = t != 1023 && t < N && pr[t] < m_rp;
    chk(ok ? "R2 ack_id" : "R1 ack_id", int'(ack_id), ok ? t : 1023);
    chk(ok ? "R2 pend_clr" : "R1 pend_clr", int'(pend_clr), int'(ok));
    if (ok) chk("R2 pend_clr_id", int'(pend_clr_id), t);
    @(negedge clk);
    ack_req = 0;
    if (ok) begin
      m_link[t] = m_run; m_run = t; m_rp = pr[t];
    end
    check_run(ok ? "R2" : "R1");
  endtask

  task automatic do_eoi(logic [31:0] d, bit probe);
    int id, k, cnt, cur;
    bit ok, es;
    @(negedge clk);
    eoi_data = d; eoi_req = 1; #1;
    id = int'(d[9:0]);
    ok = id < N && m_run != 1023;
    es = ok && lvl[id] && en[id] && ln[id] && tg[id];
    chk("R8 pend_set", int'(pend_set), int'(es));
    if (es) chk("R8 pend_set_id", int'(pend_set_id), id);
    k = 0;
    if (ok) begin
      if (id == m_run) begin
        m_run = m_link[id]; m_rp = mprio(m_run);
      end else begin
        cur = m_run;
        forever begin
          k++;
          if (m_link[cur] == 1023) break;
          if (m_link[cur] == id) begin m_link[cur] = m_link[id]; break; end
          cur = m_link[cur];
        end
      end
    end
    @(negedge clk);
    eoi_req = 0;
    cnt = 0;
    while (busy && cnt < 100) begin
      if (probe && cnt == 0) begin
        top_id = 10'd1; ack_req = 1; #1;
        chk("R9 ack while busy", int'(ack_id), 1023);
        chk("R9 pend_clr while busy", int'(pend_clr), 0);
        ack_req = 0;
      end
      cnt++;
      @(negedge clk);
    end
    chk("R9 busy cycles", cnt, k);
    check_run(ok ? (id == m_run || k == 0 ? "R6" : "R7") : "R5");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin pr[i] = (i*53 + 7) % 256; m_link[i] = 1023; end
    push_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset run_id", int'(run_id), 1023);
    chk("R3 reset run_prio", int'(run_prio), 256);
    chk("R3 reset busy", int'(busy), 0);
    chk("R3 reset ack_id", int'(ack_id), 1023);

    // R2 R6 R8 R4: sweep every source and every re-pend qualifier combination
    for (int id = 0; id < N; id++) begin
      lvl[id] = id[0]; en[id] = id[1]; ln[id] = id[2]; tg[id] = id[3];
      do_ack(id);
      do_eoi(32'hABCD_E000 | id, 0);
    end

    // R1 refusals and R5 ignored completions while idle
    do_ack(1023);
    do_ack(20);
    do_eoi(32'd15, 0);
    do_eoi(32'd1023, 0);

    // R1: acknowledge together with an end-of-interrupt is refused
    @(negedge clk);
    top_id = 10'd2; ack_req = 1; eoi_req = 1; eoi_data = 32'd2; #1;
    chk("R1 ack with eoi", int'(ack_id), 1023);
    @(negedge clk);
    ack_req = 0; eoi_req = 0;
    check_run("R1");

    // R7: nesting and out-of-order completion
    pr[5] = 8'h80; pr[3] = 8'h40; pr[9] = 8'h20; pr[12] = 8'h20; pr[1] = 8'h00;
    push_cfg();
    do_ack(5); do_ack(3); do_ack(9);
    do_ack(12);
    do_ack(5);
    do_eoi(32'd1023, 0);
    do_eoi(32'd20, 0);
    do_eoi(32'd5, 1);
    do_eoi(32'd9, 0);
    chk("R7 after splice run_id", int'(run_id), 3);
    do_eoi(32'd3, 0);
    chk("R7 chain empty", int'(run_id), 1023);
    do_ack(5);
    do_eoi(32'd7, 0);
    do_eoi(32'd5, 0);

    // mixed pseudo-random operations against the chain model
    for (int i = 0; i < N; i++) pr[i] = (i*53 + 7) % 256;
    push_cfg();
    lvl = 16'hA5C3; en = 16'hF0F5; ln = 16'h7E7E; tg = 16'hDB6D;
    for (int s = 0; s < 400; s++) begin
      int v;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      v = int'((lcg >> 16) % 20);
      if (lcg[31]) do_ack(v >= N ? 1023 : v);
      else if (v == 19 && m_run != 1023) do_eoi(32'(m_run), 0);
      else do_eoi(v == 16 ? 32'd1023 : 32'(v), 0);
    end
    finish_run();
  end
endmodule